// File: doc/BRIEF.md
# Partitioned Saturating SIMD Lane ALU

This block is the integer datapath of one 64-bit vector lane. The same 64 bits can hold one 64-bit element, two 32-bit elements or four 16-bit elements. A configuration register chooses which layout applies. That register is written rarely, typically once before a loop nest, and the opcode never carries a width. Every operation then runs on all elements of the lane in parallel, with no carry crossing from one element into the next.

The datapath performs add, subtract, AND, OR, XOR and a fixed-point multiply-add. Each element can wrap or saturate. The multiply-add takes a shift amount from the instruction, rounds, and adds a third operand, so any fixed-point format can be handled without a wide accumulator. A per-element flag bit predicates the operation. The registered output carries the 64-bit result together with byte write enables that a register file can use directly.

Top module: `simd_lane_alu`

## Requirements
- R1: The width register resets to 64-bit mode. A pulse on `cfg_we` loads `cfg_width`, where 2'b00 means one 64-bit element, 2'b01 means two 32-bit elements and 2'b10 means four 16-bit elements. A write of 2'b11 leaves the register unchanged. The value holds until the next legal write, and an operation uses the width held at the edge where it is accepted.
- R2: `op`=3'd0 adds each element modulo its width. Carries are cut at every element boundary (bits 16, 32 and 48 in 16-bit mode, bit 32 in 32-bit mode).
- R3: `op`=3'd1 computes opa minus opb per element, in two's complement, modulo the element width.
- R4: With `sat_en`=1, add and subtract treat elements as signed. A result above the element maximum becomes the maximum (0x7FFF...), and a result below the minimum becomes the minimum (0x8000...).
- R5: `op`=3'd2, 3'd3 and 3'd4 compute the bitwise AND, OR and XOR. Neither the width nor `sat_en` has any effect on them.
- R6: `op`=3'd5 computes, per signed element, ((opa*opb + h) >>> s) + opc. Here s is `shamt` clamped to at most 2*EW-1, and h is 2^(s-1) when s>0 and 0 otherwise, which rounds halves upward. The product is kept at full precision.
- R7: The multiply-add result wraps to the element width when `sat_en`=0 and clamps to the signed element range when `sat_en`=1.
- R8: Bit i of `flag_mask` enables element i, counted from the least significant element. Each `byte_we` bit equals the flag of the element that owns that byte. A disabled element has all-zero result bits.
- R9: A result appears on the first clock edge after `in_valid` is accepted, with `out_valid` high for exactly that cycle. In a cycle without a result, `byte_we` is zero. Back-to-back inputs give back-to-back results.
- R10: After reset, `out_valid`, `result` and `byte_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the width register |
| cfg_width | input | 2 | Element width code for the register |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 3 | Operation code |
| sat_en | input | 1 | Saturate instead of wrapping |
| shamt | input | 6 | Right shift of the multiply-add product |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| opc | input | 64 | Addend for multiply-add |
| flag_mask | input | 4 | Per-element execute flags |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed element results |
| byte_we | output | 8 | Per-byte write enables |

## Verification
Every result, including the write enables, is due on the clock edge right after its operation is accepted, so `out_valid` rises one cycle after `in_valid`. For each accepted operation the driver queues the expected data and enables, computed from the width that was in force when the operation was accepted. The monitor samples at the falling edge that follows each rising edge, pops one entry whenever `out_valid` is high, and flags any result that arrives with nothing queued. A width change is given its own cycle before the next operation is issued, so each operation is modelled with the width it actually sees.

// File: rtl/simd_lane_pkg.sv
// Shared types for the partitioned lane ALU.
// Assumes a lane built from NC chunks of CW bits; the encodings below are the
// values seen on the block's ports.
package simd_lane_pkg;
    localparam int CHUNK_W = 16;
    localparam int N_CHUNK = 4;
    localparam int LANE_W  = CHUNK_W * N_CHUNK;

    typedef enum logic [1:0] {
        EW_WIDE   = 2'b00,
        EW_HALF   = 2'b01,
        EW_QUART  = 2'b10
    } ew_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MAC = 3'd5
    } op_e;
endpackage

// File: rtl/simd_lane_addsub.sv
// Partitioned adder/subtractor built from CW-bit chunks.
// Carries are cut wherever a new element starts. The signed overflow of each
// element is found at its top chunk and, when saturation is on, replaces the
// whole element with the clamped value. Assumes NC is a multiple of 2.
module simd_lane_addsub
    import simd_lane_pkg::*;
#(
    parameter int CW = CHUNK_W,
    parameter int NC = N_CHUNK,
    localparam int LW = CW * NC
) (
    input  ew_e           ew,
    input  logic          sub,
    input  logic          sat,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] y
);
    logic [NC-1:0] first_c;
    logic [NC-1:0] last_c;
    logic [LW-1:0] raw;
    logic [NC-1:0] ovf;
    logic [NC-1:0] neg;

    // Mark the chunks where each element begins and ends.
    always_comb begin
        for (int k = 0; k < NC; k++) begin
            unique case (ew)
                EW_QUART: begin first_c[k] = 1'b1;            last_c[k] = 1'b1;            end
                EW_HALF:  begin first_c[k] = (k % 2 == 0);    last_c[k] = (k % 2 == 1);    end
                default:  begin first_c[k] = (k == 0);        last_c[k] = (k == NC - 1);   end
            endcase
        end
    end

    // Chunk ripple with carry kill and per-element overflow detection.
    always_comb begin
        logic          cin;
        logic [CW:0]   s;
        logic [CW-1:0] bn;
        cin = 1'b0;
        s   = '0;
        bn  = '0;
        raw = '0;
        ovf = '0;
        neg = '0;
        for (int k = 0; k < NC; k++) begin
            bn = b[k*CW +: CW] ^ {CW{sub}};
            if (first_c[k]) cin = sub;
            s = {1'b0, a[k*CW +: CW]} + {1'b0, bn} + {{CW{1'b0}}, cin};
            raw[k*CW +: CW] = s[CW-1:0];
            cin = s[CW];
            if (last_c[k]) begin
                ovf[k] = (a[k*CW+CW-1] == bn[CW-1]) && (s[CW-1] != a[k*CW+CW-1]);
                neg[k] = a[k*CW+CW-1];
            end
        end
    end

    // Replace overflowed elements with the signed limit of their width.
    always_comb begin
        int t;
        t = 0;
        y = raw;
        for (int k = 0; k < NC; k++) begin
            unique case (ew)
                EW_QUART: t = k;
                EW_HALF:  t = k | 1;
                default:  t = NC - 1;
            endcase
            if (sat && ovf[t]) begin
                if (k == t)
                    y[k*CW +: CW] = neg[t] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}};
                else
                    y[k*CW +: CW] = neg[t] ? {CW{1'b0}} : {CW{1'b1}};
            end
        end
    end
endmodule

// File: rtl/simd_lane_mac_elem.sv
// One fixed-point multiply-add element of EW bits.
// Computes ((a*b + half) >>> s) + c on signed values at full precision, where
// s is the shift clamped to 2*EW-1, then wraps or saturates to EW bits.
module simd_lane_mac_elem #(
    parameter int EW  = 16,
    parameter int SHW = 6,
    localparam int PW = 2 * EW + 2,
    localparam int SMAX = 2 * EW - 1
) (
    input  logic [EW-1:0]  a,
    input  logic [EW-1:0]  b,
    input  logic [EW-1:0]  c,
    input  logic [SHW-1:0] shamt,
    input  logic           sat,
    output logic [EW-1:0]  y
);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (EW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (EW - 1));

    logic signed [PW-1:0] ax, bx, cx, prod, rnd, shifted, total;
    int sh;

    // Product, rounding, scaling, addend and final clamp.
    always_comb begin
        ax      = PW'($signed(a));
        bx      = PW'($signed(b));
        cx      = PW'($signed(c));
        prod    = ax * bx;
        sh      = (int'(shamt) > SMAX) ? SMAX : int'(shamt);
        rnd     = (sh == 0) ? '0 : (PW'(1) <<< (sh - 1));
        shifted = (prod + rnd) >>> sh;
        total   = shifted + cx;
        if (sat && total > MAXV)      y = MAXV[EW-1:0];
        else if (sat && total < MINV) y = MINV[EW-1:0];
        else                          y = total[EW-1:0];
    end
endmodule

// File: rtl/simd_lane_mac.sv
// Multiply-add for all three partitionings.
// One generate group of elements exists per width; the width code selects
// which group drives the lane.
module simd_lane_mac
    import simd_lane_pkg::*;
#(
    parameter int CW  = CHUNK_W,
    parameter int NC  = N_CHUNK,
    parameter int SHW = 6,
    localparam int LW = CW * NC
) (
    input  ew_e            ew,
    input  logic           sat,
    input  logic [SHW-1:0] shamt,
    input  logic [LW-1:0]  a,
    input  logic [LW-1:0]  b,
    input  logic [LW-1:0]  c,
    output logic [LW-1:0]  y
);
    logic [LW-1:0] y_q, y_h, y_w;

    for (genvar i = 0; i < NC; i++) begin : g_quart
        simd_lane_mac_elem #(.EW(CW), .SHW(SHW)) u_elem (
            .a(a[i*CW +: CW]), .b(b[i*CW +: CW]), .c(c[i*CW +: CW]),
            .shamt(shamt), .sat(sat), .y(y_q[i*CW +: CW]));
    end

    for (genvar i = 0; i < NC / 2; i++) begin : g_half
        simd_lane_mac_elem #(.EW(2*CW), .SHW(SHW)) u_elem (
            .a(a[i*2*CW +: 2*CW]), .b(b[i*2*CW +: 2*CW]), .c(c[i*2*CW +: 2*CW]),
            .shamt(shamt), .sat(sat), .y(y_h[i*2*CW +: 2*CW]));
    end

    simd_lane_mac_elem #(.EW(LW), .SHW(SHW)) u_wide (
        .a(a), .b(b), .c(c), .shamt(shamt), .sat(sat), .y(y_w));

    // Pick the group matching the current partitioning.
    always_comb begin
        unique case (ew)
            EW_QUART: y = y_q;
            EW_HALF:  y = y_h;
            default:  y = y_w;
        endcase
    end
endmodule

// File: rtl/simd_lane_alu.sv
// Top of the lane ALU: width register, operation select, flag masking and
// the output register (one cycle latency). Assumes cfg_we and in_valid are
// not asserted together when the new width must apply to that operation.
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int CW  = CHUNK_W,
    parameter int NC  = N_CHUNK,
    parameter int SHW = 6,
    localparam int LW = CW * NC,
    localparam int NB = LW / 8,
    localparam int BPC = CW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_width,
    input  logic           in_valid,
    input  logic [2:0]     op,
    input  logic           sat_en,
    input  logic [SHW-1:0] shamt,
    input  logic [LW-1:0]  opa,
    input  logic [LW-1:0]  opb,
    input  logic [LW-1:0]  opc,
    input  logic [NC-1:0]  flag_mask,
    output logic           out_valid,
    output logic [LW-1:0]  result,
    output logic [NB-1:0]  byte_we
);
    ew_e           width_q;
    logic [LW-1:0] as_y, mac_y, exec_y, data_d;
    logic [NB-1:0] we_d;

    // Persistent element-width register; the reserved code is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                            width_q <= EW_WIDE;
        else if (cfg_we && cfg_width != 2'b11) width_q <= ew_e'(cfg_width);
    end

    simd_lane_addsub #(.CW(CW), .NC(NC)) u_addsub (
        .ew(width_q), .sub(op == OP_SUB), .sat(sat_en),
        .a(opa), .b(opb), .y(as_y));

    simd_lane_mac #(.CW(CW), .NC(NC), .SHW(SHW)) u_mac (
        .ew(width_q), .sat(sat_en), .shamt(shamt),
        .a(opa), .b(opb), .c(opc), .y(mac_y));

    // Choose the unit output for the opcode.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB: exec_y = as_y;
            OP_AND:         exec_y = opa & opb;
            OP_OR:          exec_y = opa | opb;
            OP_XOR:         exec_y = opa ^ opb;
            OP_MAC:         exec_y = mac_y;
            default:        exec_y = '0;
        endcase
    end

    // Spread element flags over chunks and bytes; zero disabled elements.
    always_comb begin
        logic en;
        en     = 1'b0;
        data_d = '0;
        we_d   = '0;
        for (int k = 0; k < NC; k++) begin
            unique case (width_q)
                EW_QUART: en = flag_mask[k];
                EW_HALF:  en = flag_mask[k/2];
                default:  en = flag_mask[0];
            endcase
            data_d[k*CW +: CW] = en ? exec_y[k*CW +: CW] : '0;
            we_d[k*BPC +: BPC] = {BPC{en}};
        end
    end

    // Output register: one cycle from acceptance to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            byte_we   <= '0;
        end else begin
            out_valid <= in_valid;
            byte_we   <= in_valid ? we_d : '0;
            if (in_valid) result <= data_d;
        end
    end

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(width_q));
    p_cfg_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        width_q != 2'b11);
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> byte_we == '0);
    p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && byte_we[BPC-1:0] == '0) |-> result[CW-1:0] == '0);
    p_and_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_AND && flag_mask == '1) |=> result == $past(opa & opb));
endmodule

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        sat_en = 1'b0;
    logic [5:0]  shamt = 6'd0;
    logic [63:0] opa = '0, opb = '0, opc = '0;
    logic [3:0]  flag_mask = 4'hF;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  byte_we;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [1:0] tb_w = 2'b00;

    logic [63:0] q_res[$];
    logic [7:0]  q_we[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    simd_lane_alu i_simd_lane_alu (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_width(cfg_width),
        .in_valid(in_valid), .op(op), .sat_en(sat_en), .shamt(shamt),
        .opa(opa), .opb(opb), .opc(opc), .flag_mask(flag_mask),
        .out_valid(out_valid), .result(result), .byte_we(byte_we));

    function automatic int ew_of(logic [1:0] w);
        return (w == 2'b10) ? 16 : (w == 2'b01) ? 32 : 64;
    endfunction

    // Reference result built element by element from the requirements.
    function automatic logic [63:0] model(logic [1:0] w, logic [2:0] o, bit sat, int sh,
                                          logic [63:0] a, logic [63:0] b, logic [63:0] c,
                                          logic [3:0] m);
        int ew = ew_of(w);
        logic [63:0] msk = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
        logic [63:0] res = '0;
        for (int e = 0; e < 64 / ew; e++) begin
            logic [63:0] ua = (a >> (e * ew)) & msk;
            logic [63:0] ub = (b >> (e * ew)) & msk;
            logic [63:0] uc = (c >> (e * ew)) & msk;
            logic signed [129:0] sa = $signed({66'd0, ua});
            logic signed [129:0] sb = $signed({66'd0, ub});
            logic signed [129:0] sc = $signed({66'd0, uc});
            logic signed [129:0] r;
            logic signed [129:0] hi = (130'sd1 <<< (ew - 1)) - 130'sd1;
            logic signed [129:0] lo = -(130'sd1 <<< (ew - 1));
            int s;
            bit arith = 1'b1;
            if (ua[ew-1]) sa = sa - (130'sd1 <<< ew);
            if (ub[ew-1]) sb = sb - (130'sd1 <<< ew);
            if (uc[ew-1]) sc = sc - (130'sd1 <<< ew);
            r = '0;
            case (o)
                3'd0: r = sa + sb;
                3'd1: r = sa - sb;
                3'd2: begin r = $signed({66'd0, ua & ub}); arith = 1'b0; end
                3'd3: begin r = $signed({66'd0, ua | ub}); arith = 1'b0; end
                3'd4: begin r = $signed({66'd0, ua ^ ub}); arith = 1'b0; end
                3'd5: begin
                    s = (sh > 2 * ew - 1) ? 2 * ew - 1 : sh;
                    r = sa * sb;
                    if (s > 0) r = r + (130'sd1 <<< (s - 1));
                    r = (r >>> s) + sc;
                end
                default: begin r = '0; arith = 1'b0; end
            endcase
            if (arith && sat) begin
                if (r > hi) r = hi;
                if (r < lo) r = lo;
            end
            if (m[e]) res = res | ((64'(r) & msk) << (e * ew));
        end
        return res;
    endfunction

    function automatic logic [7:0] model_we(logic [1:0] w, logic [3:0] m);
        int bpe = ew_of(w) / 8;
        logic [7:0] we = '0;
        for (int j = 0; j < 8; j++) we[j] = m[j / bpe];
        return we;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one operation and queue its expected outcome.
    task automatic issue(string tag, logic [2:0] o, bit sat, int sh,
                         logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [3:0] m);
        @(negedge clk);
        in_valid = 1'b1; op = o; sat_en = sat; shamt = 6'(sh);
        opa = a; opb = b; opc = c; flag_mask = m;
        q_res.push_back(model(tb_w, o, sat, sh, a, b, c, m));
        q_we.push_back(model_we(tb_w, m));
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_width(logic [1:0] w);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1; cfg_width = w;
        if (w != 2'b11) tb_w = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: results are due one edge after acceptance.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_res.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected result actual=%h expected=none", result);
            end else begin
                string t = q_tag.pop_front();
                chk({t, " data"}, result, q_res.pop_front());
                chk({t, " byte_we"}, {56'd0, byte_we}, {56'd0, q_we.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R10 result", result, 64'd0);
        chk("R10 byte_we", {56'd0, byte_we}, 64'd0);

        // R1 default 64-bit width, R2 carry through the whole lane
        issue("R2 add64", 3'd0, 0, 0, 64'h0000_FFFF_FFFF_FFFF, 64'd1, 0, 4'h1);
        set_width(2'b01);
        issue("R2 add32 carry kill", 3'd0, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 4'h3);
        set_width(2'b10);
        issue("R2 add16 carry kill", 3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 0, 4'hF);
        issue("R3 sub16", 3'd1, 0, 0, 64'h0000_0005_8000_1234, 64'h0001_0007_0001_0234, 0, 4'hF);
        issue("R4 sat add16", 3'd0, 1, 0, 64'h7FFF_8000_7000_0010, 64'h0001_FFFF_7000_0020, 0, 4'hF);
        issue("R4 sat sub16", 3'd1, 1, 0, 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0003, 0, 4'hF);
        issue("R5 and sat16", 3'd2, 1, 0, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_7FFF_FFFF, 0, 4'hF);
        issue("R6 mac16 q15", 3'd5, 0, 15, 64'h4000_0001_C000_7FFF, 64'h6000_0001_4000_7FFF, 64'h0000_0002_0010_0000, 4'hF);
        issue("R6 mac16 round", 3'd5, 0, 1, 64'h0003_0001_FFFD_FFFF, 64'h0001_0001_0001_0001, 0, 4'hF);
        issue("R6 mac16 shift clamp", 3'd5, 0, 40, 64'h8000_1234_8000_0001, 64'h8000_1234_7FFF_0001, 0, 4'hF);
        issue("R7 mac16 sat", 3'd5, 1, 0, 64'h7FFF_8000_0100_0003, 64'h7FFF_7FFF_0100_0004, 64'h0000_0000_0000_0005, 4'hF);
        issue("R8 mask16", 3'd0, 0, 0, 64'h1111_2222_3333_4444, 64'h1111_1111_1111_1111, 0, 4'b0101);
        idle(2);
        chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 idle byte_we", {56'd0, byte_we}, 64'd0);

        set_width(2'b01);
        set_width(2'b11);
        issue("R1 reserved code ignored", 3'd0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 4'h3);
        issue("R4 sat sub32", 3'd1, 1, 0, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 0, 4'h3);
        issue("R7 mac32 wrap", 3'd5, 0, 0, 64'h0001_0000_7FFF_FFFF, 64'h0001_0000_0000_0002, 64'h0000_0000_0000_0001, 4'h3);
        issue("R7 mac32 sat", 3'd5, 1, 0, 64'h0001_0000_7FFF_FFFF, 64'h0001_0000_0000_0002, 64'h0000_0000_0000_0001, 4'h3);
        issue("R8 mask32", 3'd4, 0, 0, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 0, 4'b0010);
        issue("R5 or32", 3'd3, 0, 0, 64'h0F0F_0000_1200_0034, 64'hF000_0F00_0034_1200, 0, 4'h3);

        set_width(2'b00);
        issue("R4 sat add64", 3'd0, 1, 0, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100, 0, 4'h1);
        issue("R6 mac64", 3'd5, 0, 8, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_0007, 4'h1);
        issue("R3 sub64", 3'd1, 0, 0, 64'd0, 64'd1, 0, 4'h1);
        issue("R8 mask64 off", 3'd0, 0, 0, 64'h1234, 64'h1, 0, 4'hE);
        idle(3);

        chk("R9 queue drained", 64'(q_res.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule